// File: doc/BRIEF.md
# Scanned Display Word Store with Self-Advancing Write Pointer

This block holds the segment patterns for a multiplexed grid display: sixteen words of sixteen bits, one word per grid digit. Word address 0 belongs to the first grid, address 1 to the second, and so on up to address 15 for the sixteenth. A host writes patterns one after another through a write strobe. Each write lands at the position held in an internal 4-bit pointer, and the pointer then steps forward by one. After the last word the pointer wraps back to the first, whatever number of digits the scan logic happens to be using. A separate load strobe moves the pointer to any position, so a single digit can be rewritten without sending the whole frame again.

The scan logic has its own read port. It presents the address of the digit it is about to drive and receives that word one clock later. Bit i of the word is the drive level for segment i, in positive logic: 1 lights the segment. A write to the word that is being read does not disturb the value returned in that cycle. The new pattern appears the next time that address is read.

Top module: `disp_ram_top`

## Requirements
- R1: After synchronous reset the write pointer is 0, so the first write goes to address 0, and `rd_data` reads 0.
- R2: With `wr_en` high and `ld_en` low, `wr_data` is stored at the pointer address and the pointer becomes pointer+1.
- R3: The pointer wraps from 15 to 0, so the 17th write after a pointer value of 0 overwrites address 0 and leaves address 1 intact.
- R4: With `ld_en` high, the pointer takes the value on `ld_ptr`, and the next write goes to that address.
- R5: If `ld_en` and `wr_en` are high in the same cycle, the load wins, the write is dropped, and no word changes.
- R6: `rd_data` presents, one clock after `rd_addr` is sampled, the word stored at that address. Bit i carries segment i unchanged, in positive logic.
- R7: When a write and a read hit the same address on one edge, `rd_data` shows the old word on that edge and the new word on the next read.
- R8: With neither strobe high the pointer holds, and the next write goes to the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Store `wr_data` at the pointer, then advance the pointer |
| wr_data | input | 16 | Segment pattern; bit i drives segment i |
| ld_en | input | 1 | Load the pointer from `ld_ptr` |
| ld_ptr | input | 4 | New pointer value |
| rd_addr | input | 4 | Digit address requested by the scan logic |
| rd_data | output | 16 | Registered word read from `rd_addr` |

## Verification
A write or a pointer load takes effect on the rising edge that samples its strobe. A read address sampled on one edge yields its word on `rd_data` right after that same edge, so a word written on edge k can be read back after edge k+1 at the earliest. The bench changes inputs on the falling edge and samples outputs 1 ns after a rising edge, so each result is read in the cycle it is due. In the same-slot test the old word is read right after the write edge and the new word right after the following edge.

// File: rtl/disp_ram_pkg.sv
package disp_ram_pkg;
    localparam int DIGITS = 16;
    localparam int SEG_W  = 16;
    localparam int PTR_W  = $clog2(DIGITS);

    typedef logic [PTR_W-1:0] ptr_t;
    typedef logic [SEG_W-1:0] word_t;

    typedef enum logic [1:0] {
        PTR_HOLD = 2'd0,
        PTR_LOAD = 2'd1,
        PTR_STEP = 2'd2
    } ptr_op_e;

    typedef struct packed {
        logic  en;
        ptr_t  addr;
        word_t data;
    } wr_req_t;

    // A load outranks a data write; a write steps the pointer.
    function automatic ptr_op_e pick_op(input logic ld, input logic wr);
        if (ld)      return PTR_LOAD;
        else if (wr) return PTR_STEP;
        else         return PTR_HOLD;
    endfunction

    // Modulo-DIGITS successor, also correct when DIGITS is not a power of two.
    function automatic ptr_t ptr_succ(input ptr_t p);
        if (int'(p) == DIGITS - 1) return '0;
        else                       return p + ptr_t'(1);
    endfunction
endpackage

// File: rtl/disp_wptr.sv
module disp_wptr
    import disp_ram_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ptr_op_e op,
    input  ptr_t    ld_val,
    output ptr_t    ptr
);
    ptr_t ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            unique case (op)
                PTR_LOAD: ptr_q <= ld_val;
                PTR_STEP: ptr_q <= ptr_succ(ptr_q);
                default:  ptr_q <= ptr_q;
            endcase
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/disp_mem.sv
module disp_mem
    import disp_ram_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wr,
    input  ptr_t    rd_addr,
    output word_t   rd_data
);
    word_t words [DIGITS];
    word_t rd_q;

    // One write decoder per word.
    for (genvar g = 0; g < DIGITS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr.en && (int'(wr.addr) == g))
                words[g] <= wr.data;
        end
    end

    // Registered read: the old word is returned when the same address is written.
    always_ff @(posedge clk) begin
        if (rst) rd_q <= '0;
        else     rd_q <= words[rd_addr];
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/disp_ram_top.sv
module disp_ram_top
    import disp_ram_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [SEG_W-1:0]      wr_data,
    input  logic                  ld_en,
    input  logic [PTR_W-1:0]      ld_ptr,
    input  logic [PTR_W-1:0]      rd_addr,
    output logic [SEG_W-1:0]      rd_data
);
    ptr_op_e op;
    ptr_t    cur_ptr;
    wr_req_t req;

    assign op = pick_op(ld_en, wr_en);

    always_comb begin
        req.en   = (op == PTR_STEP);
        req.addr = cur_ptr;
        req.data = wr_data;
    end

    disp_wptr u_wptr (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .ld_val (ld_ptr),
        .ptr    (cur_ptr)
    );

    disp_mem u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr      (req),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/disp_ram_chk.sv
module disp_ram_chk
    import disp_ram_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             ld_en,
    input logic [PTR_W-1:0] ld_ptr,
    input logic [PTR_W-1:0] ptr,
    input logic [SEG_W-1:0] rd_data
);
    // R1
    ptr_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ptr == '0 && rd_data == '0));

    // R2
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ld_en && ptr != PTR_W'(DIGITS - 1)) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

    // R3
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ld_en && ptr == PTR_W'(DIGITS - 1)) |=> (ptr == '0));

    // R4
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (ptr == $past(ld_ptr)));

    // R8
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !ld_en) |=> $stable(ptr));
endmodule

bind disp_ram_top disp_ram_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .ld_en   (ld_en),
    .ld_ptr  (ld_ptr),
    .ptr     (cur_ptr),
    .rd_data (rd_data)
);

// File: tb/tb_disp_ram_top.sv
`timescale 1ns/1ps
module tb_disp_ram_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_ptr = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] model [16];
    int mptr = 0;

    always #2.5 clk = ~clk;

    disp_ram_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .ld_en(ld_en), .ld_ptr(ld_ptr), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[mptr] = d;
        mptr = (mptr + 1) % 16;
    endtask

    task automatic do_load(input logic [3:0] p);
        @(negedge clk);
        ld_en = 1'b1; ld_ptr = p;
        @(negedge clk);
        ld_en = 1'b0;
        mptr = p;
    endtask

    task automatic read_word(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_addr = a;
        @(posedge clk);
        #1 v = rd_data;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mptr = 0;
        #0.5 check("R1 rd_data after reset", rd_data, 16'h0000);
        do_write(16'hA5C3);
        read_word(4'd0, v);
        check("R1 first write lands at 0", v, 16'hA5C3);
    endtask

    task automatic t_fill();
        logic [15:0] v;
        for (int i = 1; i < 16; i++) do_write(16'h1111 * i[15:0] ^ (16'h0001 << i));
        for (int i = 0; i < 16; i++) begin
            read_word(i[3:0], v);
            check("R2 sequential fill", v, model[i]);
        end
        read_word(4'd7, v);
        check("R6 positive logic bit map", v, model[7]);
    endtask

    task automatic t_patterns();
        logic [15:0] v;
        do_load(4'd2);
        do_write(16'hFFFF);
        do_write(16'h0000);
        do_write(16'h8001);
        for (int i = 2; i < 5; i++) begin
            read_word(i[3:0], v);
            check("R6 pattern readback", v, model[i]);
        end
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        do_load(4'd0);
        for (int i = 0; i < 17; i++) do_write(16'h0F00 + 16'(i));
        read_word(4'd0, v);
        check("R3 wrap overwrites word 0", v, 16'h0F10);
        read_word(4'd1, v);
        check("R3 word 1 intact after wrap", v, 16'h0F01);
        read_word(4'd15, v);
        check("R3 word 15 written before wrap", v, 16'h0F0F);
    endtask

    task automatic t_load();
        logic [15:0] v;
        do_load(4'd9);
        do_write(16'h3C3C);
        do_write(16'hC3C3);
        read_word(4'd9, v);
        check("R4 load then write at 9", v, 16'h3C3C);
        read_word(4'd10, v);
        check("R4 step after load to 10", v, 16'hC3C3);
    endtask

    task automatic t_hold();
        logic [15:0] v;
        // pointer now 11; idle cycles must not move it
        repeat (5) @(negedge clk);
        do_write(16'h7E7E);
        read_word(4'd11, v);
        check("R8 pointer held while idle", v, 16'h7E7E);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        logic [15:0] old12;
        old12 = model[12];
        // pointer is 12 here; load 4 while also writing
        @(negedge clk);
        ld_en = 1'b1; ld_ptr = 4'd4; wr_en = 1'b1; wr_data = 16'hDEAD;
        @(negedge clk);
        ld_en = 1'b0; wr_en = 1'b0;
        mptr = 4;
        read_word(4'd12, v);
        check("R5 dropped write leaves word 12", v, old12);
        read_word(4'd4, v);
        check("R5 dropped write leaves word 4", v, model[4]);
        do_write(16'hBEEF);
        read_word(4'd4, v);
        check("R5 load won, next write at 4", v, 16'hBEEF);
    endtask

    task automatic t_same_slot();
        logic [15:0] old5;
        old5 = model[5];
        do_load(4'd5);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 16'h5A5A; rd_addr = 4'd5;
        @(posedge clk);
        #1 check("R7 old word during write", rd_data, old5);
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk);
        #1 check("R7 new word on next read", rd_data, 16'h5A5A);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_patterns();
        t_wrap();
        t_load();
        t_hold();
        t_collide();
        t_same_slot();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule